// File: doc/BRIEF.md
# Byte-Lane Static RAM Cycle Controller

This block sits between a synchronous host and an asynchronous 16-bit static RAM. The RAM has an active-low chip select, output gate, write strobe and one active-low enable per byte lane. The host presents one request at a time: an address, write data, a byte mask and a direction flag. It holds the request until the controller returns a one-cycle acknowledge, and for reads the read data arrives on that same cycle. The controller then produces RAM cycles that meet the device's access, strobe-width, setup and bus-turnaround limits.

Every limit is a nanosecond parameter. Each one becomes a cycle count by ceiling division by the clock period, with a floor of one cycle. A read holds select and output gate low for the longest of the cycle-time, address-access and gate-access counts. A write holds the strobe low for the longest of these: the pulse width, the select-to-end time, the write cycle less its one tail cycle, and the bus-release wait plus the data setup. The controller drives the data bus only after the RAM has had time to let it go. It releases the write strobe before the select so that the strobe alone ends the write.

With the default parameters (10 ns clock, 45/45/22 ns read limits, 18 ns release times, 35 ns strobe and select limits, 45 ns write cycle, 25 ns data setup), a read lasts 5 cycles, the write strobe lasts 5 cycles, and the data bus turns on 2 cycles after the strobe falls.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is low and at the first clock after it, select, output gate, write strobe and both lane enables are high, the bus drive enable and acknowledge are low, and address and read data are zero.
- R2: A read with a nonzero mask drives select and output gate low with the address at the accepting edge, keeps the write strobe high, and holds select and output gate low for exactly 5 cycles (default).
- R3: At the edge that ends a read, the read data lanes whose mask bit is 1 (bit 0 = bits 7:0, bit 1 = bits 15:8) capture the RAM bus, lanes with mask bit 0 keep their old value, and acknowledge is high for the following cycle.
- R4: A write drives select and write strobe low at the accepting edge, keeps the output gate high throughout, holds the strobe low for exactly 5 cycles, keeps select low for one more cycle after the strobe rises, then raises select.
- R5: In a write, the bus drive enable rises 2 cycles after the strobe falls and falls at the edge where select rises. While it is high the bus carries the request's write data, and it is high for at least 3 cycles before the strobe rises.
- R6: The lane enables (low for each mask bit that is 1) and the RAM address change only at an edge where select falls, and stay stable at every other edge.
- R7: A request with mask 0 is acknowledged on the cycle after it is accepted, with no select, strobe or gate activity and no change to read data.
- R8: Acknowledge lasts one cycle, and no access starts at the edge that ends the acknowledge cycle. A request held valid through acknowledge starts at the next edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte lanes to access, bit 0 = low byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid with acknowledge |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce_n | output | 1 | RAM select, active low |
| sram_oe_n | output | 1 | RAM output gate, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_be_n | output | DATA_W/8 | RAM byte-lane enables, active low |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pad |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
A wrong phase count appears at the RAM pins within one access: the strobe or select edges move by a cycle against the reference model. The bench's RAM model then returns a marker word instead of stored data, so the next read shows a corrupt result. A lane enable latched from the wrong mask bit corrupts memory contents, and the error shows at the next read of that word. A stuck acknowledge or a re-accepted request shows up on the cycle after acknowledge as an early select fall or a doubled pulse.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_RD,
      PH_WR_STROBE,
      PH_WR_TAIL
   } sram_phase_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a,
                                        input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (cnt != {CNT_W{1'b1}}) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sram_lane_unit.sv
module sram_lane_unit #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              capture,
   input  logic              mask_bit,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [LANE_W-1:0] bus_lane,
   output logic              be_n,
   output logic [LANE_W-1:0] wr_out,
   output logic [LANE_W-1:0] rd_out
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         be_n   <= 1'b1;
         wr_out <= '0;
         rd_out <= '0;
      end else begin
         if (load) begin
            be_n   <= ~mask_bit;
            wr_out <= wr_lane;
         end
         if (capture && !be_n) begin
            rd_out <= bus_lane;
         end
      end
   end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned CLK_NS     = 10,
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned T_RC_NS    = 45,
   parameter int unsigned T_AA_NS    = 45,
   parameter int unsigned T_DOE_NS   = 22,
   parameter int unsigned T_HZ_NS    = 18,
   parameter int unsigned T_HZWE_NS  = 18,
   parameter int unsigned T_PWE_NS   = 35,
   parameter int unsigned T_SCE_NS   = 35,
   parameter int unsigned T_WC_NS    = 45,
   parameter int unsigned T_SD_NS    = 25
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_mask,
   output logic                ack,
   output logic [DATA_W-1:0]   rd_data,
   output logic [ADDR_W-1:0]   sram_addr,
   output logic                sram_ce_n,
   output logic                sram_oe_n,
   output logic                sram_we_n,
   output logic [DATA_W/8-1:0] sram_be_n,
   output logic [DATA_W-1:0]   sram_dq_out,
   output logic                sram_dq_oe,
   input  logic [DATA_W-1:0]   sram_dq_in
);

   localparam int unsigned LANES    = DATA_W / 8;
   // edges from one release to the earliest next accept (ack cycle + idle)
   localparam int unsigned IDLE_GAP = 2;

   localparam int unsigned RC_C   = ns_to_cycles(T_RC_NS,   CLK_NS);
   localparam int unsigned AA_C   = ns_to_cycles(T_AA_NS,   CLK_NS);
   localparam int unsigned DOE_C  = ns_to_cycles(T_DOE_NS,  CLK_NS);
   localparam int unsigned HZ_C   = ns_to_cycles(T_HZ_NS,   CLK_NS);
   localparam int unsigned HZWE_C = ns_to_cycles(T_HZWE_NS, CLK_NS);
   localparam int unsigned PWE_C  = ns_to_cycles(T_PWE_NS,  CLK_NS);
   localparam int unsigned SCE_C  = ns_to_cycles(T_SCE_NS,  CLK_NS);
   localparam int unsigned WC_C   = ns_to_cycles(T_WC_NS,   CLK_NS);
   localparam int unsigned SD_C   = ns_to_cycles(T_SD_NS,   CLK_NS);

   localparam int unsigned RD_C   = max2(max2(RC_C, AA_C), DOE_C);
   localparam int unsigned HZ_REM = (HZ_C > IDLE_GAP) ? (HZ_C - IDLE_GAP) : 1;
   localparam int unsigned DRV_C  = max2(HZWE_C, HZ_REM);
   localparam int unsigned WC_LOW = (WC_C > 1) ? (WC_C - 1) : 1;
   localparam int unsigned WE_C   = max2(max2(PWE_C, SCE_C),
                                         max2(WC_LOW, DRV_C + SD_C));
   localparam int unsigned MAX_C  = max2(RD_C, WE_C);
   localparam int unsigned CNT_W  = $clog2(MAX_C + 2);

   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_C - 1);
   localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRV_C - 1);
   localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_C - 1);

   // elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("sram_byte_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_byte_ctrl: ADDR_W must be at least 1");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_byte_ctrl: CLK_NS must be at least 1");
   end

   sram_phase_e      phase_q;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic             start_access;
   logic             capture;
   logic             ack_q;
   logic             ce_n_q;
   logic             oe_n_q;
   logic             we_n_q;
   logic             dq_oe_q;
   logic [ADDR_W-1:0] addr_q;

   assign accept       = (phase_q == PH_IDLE) && !ack_q && req_valid;
   assign start_access = accept && (|req_mask);
   assign capture      = (phase_q == PH_RD) && (cnt == RD_LAST);

   sram_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_access),
      .cnt     (cnt)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane_unit #(
         .LANE_W (8)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (start_access),
         .capture  (capture),
         .mask_bit (req_mask[g]),
         .wr_lane  (req_wdata[g*8 +: 8]),
         .bus_lane (sram_dq_in[g*8 +: 8]),
         .be_n     (sram_be_n[g]),
         .wr_out   (sram_dq_out[g*8 +: 8]),
         .rd_out   (rd_data[g*8 +: 8])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ack_q   <= 1'b0;
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         ack_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  if (!(|req_mask)) begin
                     ack_q <= 1'b1;
                  end else begin
                     addr_q <= req_addr;
                     ce_n_q <= 1'b0;
                     if (req_write) begin
                        we_n_q  <= 1'b0;
                        phase_q <= PH_WR_STROBE;
                     end else begin
                        oe_n_q  <= 1'b0;
                        phase_q <= PH_RD;
                     end
                  end
               end
            end
            PH_RD: begin
               if (cnt == RD_LAST) begin
                  ce_n_q  <= 1'b1;
                  oe_n_q  <= 1'b1;
                  ack_q   <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            PH_WR_STROBE: begin
               if (cnt == DRV_LAST) begin
                  dq_oe_q <= 1'b1;
               end
               if (cnt == WE_LAST) begin
                  we_n_q  <= 1'b1;
                  phase_q <= PH_WR_TAIL;
               end
            end
            PH_WR_TAIL: begin
               ce_n_q  <= 1'b1;
               dq_oe_q <= 1'b0;
               ack_q   <= 1'b1;
               phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign ack        = ack_q;
   assign sram_addr  = addr_q;
   assign sram_ce_n  = ce_n_q;
   assign sram_oe_n  = oe_n_q;
   assign sram_we_n  = we_n_q;
   assign sram_dq_oe = dq_oe_q;

endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
   parameter int unsigned ADDR_W  = 18,
   parameter int unsigned LANES   = 2,
   parameter int unsigned WE_MIN  = 5,
   parameter int unsigned RD_MIN  = 5,
   parameter int unsigned DRV_MIN = 2,
   parameter int unsigned SD_MIN  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic [LANES-1:0]  sram_be_n,
   input logic              sram_dq_oe
);

   logic [15:0] we_low;
   logic [15:0] rd_low;
   logic [15:0] drv_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_low  <= '0;
         rd_low  <= '0;
         drv_len <= '0;
      end else begin
         we_low  <= sram_we_n  ? 16'd0 : ((we_low  == 16'hFFFF) ? we_low  : we_low  + 16'd1);
         rd_low  <= sram_oe_n  ? 16'd0 : ((rd_low  == 16'hFFFF) ? rd_low  : rd_low  + 16'd1);
         drv_len <= !sram_dq_oe ? 16'd0 : ((drv_len == 16'hFFFF) ? drv_len : drv_len + 16'd1);
      end
   end

   AST_READ_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> (rd_low >= 16'(RD_MIN))) else $error("read too short"); // R2
   AST_GATE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n || sram_dq_oe) |-> sram_oe_n) else $error("gate low in write"); // R4
   AST_STROBE_WIDTH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_low >= 16'(WE_MIN))) else $error("strobe short"); // R4
   AST_STROBE_ENDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_ce_n) |-> $past(sram_we_n)) else $error("select ended write"); // R4
   AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> (!sram_we_n && we_low >= 16'(DRV_MIN))) else $error("early drive"); // R5
   AST_DATA_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (sram_dq_oe && drv_len >= 16'(SD_MIN))) else $error("setup short"); // R5
   AST_DRIVE_ENDS_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_dq_oe) |-> $rose(sram_ce_n)) else $error("drive end misplaced"); // R5
   AST_LANES_ONLY_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sram_be_n) |-> $fell(sram_ce_n)) else $error("lane enable moved"); // R6
   AST_ADDR_ONLY_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sram_addr) |-> $fell(sram_ce_n)) else $error("address moved"); // R6
   AST_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (sram_ce_n && sram_we_n && sram_oe_n)) else $error("ack while busy"); // R7
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack) else $error("ack too long"); // R8
   AST_NO_START_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> sram_ce_n) else $error("access right after ack"); // R8

endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .LANES   (LANES),
   .WE_MIN  (WE_C),
   .RD_MIN  (RD_C),
   .DRV_MIN (DRV_C),
   .SD_MIN  (SD_C)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack        (ack),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_oe_n  (sram_oe_n),
   .sram_we_n  (sram_we_n),
   .sram_be_n  (sram_be_n),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_byte_ctrl_tb.sv
module sram_byte_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;
   // expected cycle counts from the default ns limits on a 10 ns clock
   localparam int LR  = 5;  // max(45,45,22 ns) -> 5
   localparam int LW  = 5;  // max(35,35,45-10,20+25 ns) -> 5
   localparam int DRV = 2;  // 18 ns release -> 2
   localparam int DOE_C = 3;
   localparam int AA_C  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic          ack;
   logic [15:0]   rd_data;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [1:0]    sram_be_n;
   logic [15:0]   sram_dq_out;
   logic [15:0]   sram_dq_in;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_byte_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .ack(ack), .rd_data(rd_data), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   // ---------------- behavioural RAM ----------------
   logic [15:0] mem [16];
   int oe_cnt = 0;
   int ce_cnt = 0;

   always @(posedge clk) begin
      oe_cnt <= sram_oe_n ? 0 : oe_cnt + 1;
      ce_cnt <= sram_ce_n ? 0 : ce_cnt + 1;
   end

   assign sram_dq_in = (!sram_ce_n && !sram_oe_n && (oe_cnt + 1) >= DOE_C &&
                        (ce_cnt + 1) >= AA_C) ? mem[sram_addr[3:0]] : 16'hBAD0;

   always @(posedge sram_we_n) begin
      if (rst_n && !sram_ce_n) begin
         for (int l = 0; l < 2; l++) begin
            if (!sram_be_n[l])
               mem[sram_addr[3:0]][l*8 +: 8] <= sram_dq_oe ? sram_dq_out[l*8 +: 8] : 8'hEE;
         end
      end
   end

   // ---------------- reference model ----------------
   logic [15:0]   shadow [16];
   int            m_kind = 0;   // 0 idle, 1 read, 2 write
   int            m_t = 0;
   bit            m_ack = 0, m_ce = 1, m_oe = 1, m_we = 1, m_drv = 0, a_next = 0;
   logic [1:0]    m_be = 2'b11, m_mask = 2'b00;
   logic [AW-1:0] m_addr = '0;
   logic [15:0]   m_wd = '0, m_rd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_kind = 0; m_t = 0; m_ack = 0; m_ce = 1; m_oe = 1; m_we = 1; m_drv = 0;
         m_be = 2'b11; m_addr = '0; m_wd = '0; m_rd = '0;
      end else begin
         a_next = 0;
         case (m_kind)
            0: if (!m_ack && req_valid) begin
                  if (req_mask == 2'b00) a_next = 1;
                  else begin
                     m_kind = req_write ? 2 : 1; m_t = 0; m_ce = 0;
                     m_addr = req_addr; m_be = ~req_mask; m_mask = req_mask; m_wd = req_wdata;
                     if (req_write) m_we = 0; else m_oe = 0;
                  end
               end
            1: begin
                  m_t++;
                  if (m_t == LR) begin
                     m_ce = 1; m_oe = 1; a_next = 1; m_kind = 0;
                     for (int l = 0; l < 2; l++)
                        if (m_mask[l]) m_rd[l*8 +: 8] = shadow[m_addr[3:0]][l*8 +: 8];
                  end
               end
            default: begin
                  m_t++;
                  if (m_t == DRV) m_drv = 1;
                  if (m_t == LW) m_we = 1;
                  if (m_t == LW + 1) begin
                     m_ce = 1; m_drv = 0; a_next = 1; m_kind = 0;
                     for (int l = 0; l < 2; l++)
                        if (m_mask[l]) shadow[m_addr[3:0]][l*8 +: 8] = m_wd[l*8 +: 8];
                  end
               end
         endcase
         m_ack = a_next;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R2 R4", "sram_ce_n", 32'(sram_ce_n), 32'(m_ce));
         check("R2", "sram_oe_n", 32'(sram_oe_n), 32'(m_oe));
         check("R4", "sram_we_n", 32'(sram_we_n), 32'(m_we));
         check("R6", "sram_be_n", 32'(sram_be_n), 32'(m_be));
         check("R6", "sram_addr", 32'(sram_addr), 32'(m_addr));
         check("R5", "sram_dq_oe", 32'(sram_dq_oe), 32'(m_drv));
         if (m_drv) check("R5", "sram_dq_out", 32'(sram_dq_out), 32'(m_wd));
         check("R8", "ack", 32'(ack), 32'(m_ack));
         check("R3", "rd_data", 32'(rd_data), 32'(m_rd));
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // ---------------- host ----------------
   bit strobed;

   task automatic do_req(input bit wr, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] m, input bit keep);
      req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
      strobed = 0;
      do begin
         @(negedge clk);
         if (!sram_ce_n || !sram_we_n || !sram_oe_n) strobed = 1;
      end while (!ack);
      if (!keep) req_valid = 1'b0;
   endtask

   logic [15:0] rd_before;

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
         shadow[i] = 16'(i * 16'h0101) ^ 16'h5A00;
      end
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", "ce_n", 32'(sram_ce_n), 32'd1);
      check("R1", "oe_n/we_n", {30'd0, sram_oe_n, sram_we_n}, 32'd3);
      check("R1", "be_n", 32'(sram_be_n), 32'd3);
      check("R1", "dq_oe/ack", {30'd0, sram_dq_oe, ack}, 32'd0);
      check("R1", "addr/rd", {14'd0, sram_addr} | 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ce_n after release", 32'(sram_ce_n), 32'd1);

      do_req(1, 18'h00003, 16'hA55A, 2'b11, 0);          // R4 R5 full write
      repeat (3) @(negedge clk);
      do_req(0, 18'h00003, 16'h0000, 2'b11, 0);          // R2 R3 read back
      check("R3", "read full word", 32'(rd_data), 32'h0000A55A);
      do_req(1, 18'h00005, 16'h1234, 2'b01, 0);          // low lane only
      do_req(0, 18'h00005, 16'h0000, 2'b10, 0);          // high lane only
      check("R3", "masked read keeps low lane", 32'(rd_data[7:0]), 32'h5A);
      do_req(0, 18'h00005, 16'h0000, 2'b11, 0);
      check("R3", "lane write preserved high", 32'(rd_data), 32'h00005F34);
      // R7: zero mask, read then write
      rd_before = rd_data;
      do_req(0, 18'h00009, 16'h0000, 2'b00, 0);
      check("R7", "no strobe on zero-mask read", 32'(strobed), 32'd0);
      check("R7", "rd_data unchanged", 32'(rd_data), 32'(rd_before));
      do_req(1, 18'h00009, 16'hFFFF, 2'b00, 0);
      check("R7", "no strobe on zero-mask write", 32'(strobed), 32'd0);
      // R8: back-to-back with request held through ack
      do_req(1, 18'h0000A, 16'hBEEF, 2'b10, 1);
      do_req(1, 18'h0000B, 16'hCAFE, 2'b11, 1);
      do_req(0, 18'h0000A, 16'h0000, 2'b11, 1);
      check("R8", "back-to-back lane write", 32'(rd_data), 32'(16'hBE00 | 16'(shadow[10][7:0])));
      do_req(0, 18'h0000B, 16'h0000, 2'b11, 0);
      check("R8", "back-to-back read", 32'(rd_data), 32'h0000CAFE);
      repeat (4) @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule